// File: doc/BRIEF.md
# Hub Port Status LED Encoder

This block turns the state of each downstream port of a USB hub into a pair of indicator lamps, one yellow and one green, per port. It takes the hub-wide conditions (enumeration finished, upstream bus reset, upstream suspend) and, for every port, the per-port conditions (device connected, low-speed device, port power on, traffic pulse, overcurrent, babble). From these it picks one display class by fixed priority and drives the two lamps steady on, steady off, or blinking. The blinking uses one shared timebase, and the two lamps can blink in phase or in anti-phase.

After reset every lamp is lit as a lamp test until the hub reports that enumeration is done. From then on, a connected device shows its speed on one steady lamp, and traffic makes the other lamp blink. Faults are latched, so a short overcurrent or babble event stays visible until the port is unplugged or its power is switched back on. A single-cycle traffic pulse is stretched so that the blink can be seen. The LED outputs are registered and active-high. All inputs are plain level or pulse signals, so there is no stream handshake and no back-pressure.

Top module: `hub_port_led`

## Requirements
- R1: From reset until `enum_done` has been seen high once, every lamp of every port is on. The lamps go off two clock edges after `enum_done` is first sampled high, and they stay off while no port has a device.
- R2: While `bus_reset` is high, both lamps of every port are steady on. This overrides suspend, faults and device display, and applies from the first edge after it rises.
- R3: While `bus_suspend` is high and `bus_reset` is low, both lamps of every port are steady off. This overrides faults and device display.
- R4: For a connected low-speed device (`port_low_speed`=1), yellow is steady on and green is off. While traffic is stretched, green blinks with the timebase and yellow stays on.
- R5: For a connected full-speed device (`port_low_speed`=0), green is steady on and yellow is off. While traffic is stretched, yellow blinks and green stays on.
- R6: A latched overcurrent makes both lamps of the port blink together, in phase. This takes priority over a latched babble and over the device display.
- R7: A latched babble, with no overcurrent latched, makes the two lamps blink in anti-phase (yellow is never equal to green).
- R8: A one-cycle `port_overcurrent` or `port_babble` pulse sets a fault latch that holds after the input drops. The latch clears when `port_conn` is low, or on the edge where `port_pwr` rises from low to high. A set in the same cycle wins over a clear.
- R9: With no device connected and no fault latched, both lamps of the port are off.
- R10: The blink phase toggles every CLK_HZ/BLINK_HZ clock cycles (a 4 Hz toggle by default).
- R11: A single-cycle traffic pulse keeps the traffic blink active for 2*CLK_HZ/BLINK_HZ cycles, then the display returns to steady. A new pulse restarts the window.
- R12: A change of connect, speed, bus reset or suspend reaches the lamps at the next clock edge. A fault or traffic pulse reaches them one edge after it is latched or stretched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enum_done | input | 1 | Hub enumeration finished (ends the lamp test) |
| bus_reset | input | 1 | Upstream bus reset in progress |
| bus_suspend | input | 1 | Upstream bus suspended |
| port_conn | input | N_PORTS | Device detected on port |
| port_low_speed | input | N_PORTS | 1 = low-speed device, 0 = full-speed |
| port_pwr | input | N_PORTS | Port power switched on |
| port_traffic | input | N_PORTS | Single-cycle traffic pulse |
| port_overcurrent | input | N_PORTS | Overcurrent event |
| port_babble | input | N_PORTS | Babble event |
| led_yel | output | N_PORTS | Yellow lamp enable, active high |
| led_grn | output | N_PORTS | Green lamp enable, active high |

## Verification
Level conditions (connect, speed, bus reset, suspend) are due one edge after they are driven. The bench drives them on a falling edge, waits one rising edge and samples on the next falling edge. The end of the lamp test is due after two edges, and a fault or traffic pulse after one edge more, because each passes through a latch or stretcher. The blink windows are sampled for exactly 2*CLK_HZ/BLINK_HZ cycles from the first edge at which the pattern is due, so any run of that length must contain a phase toggle. The return to steady is checked on the first edge after the stretch window closes.

// File: rtl/hub_led_pkg.sv
package hub_led_pkg;

  // display classes, listed from highest to lowest priority
  typedef enum logic [2:0] {
    SHOW_LAMP    = 3'd0,
    SHOW_RESET   = 3'd1,
    SHOW_SUSPEND = 3'd2,
    SHOW_OVC     = 3'd3,
    SHOW_BABBLE  = 3'd4,
    SHOW_DEVICE  = 3'd5,
    SHOW_EMPTY   = 3'd6
  } show_e;

  typedef struct packed {
    logic yel;
    logic grn;
  } led_pair_t;

  function automatic show_e pick_show(input logic lamp, input logic brst,
                                      input logic susp, input logic ovc,
                                      input logic bab, input logic conn);
    show_e s;
    if (lamp)       s = SHOW_LAMP;
    else if (brst)  s = SHOW_RESET;
    else if (susp)  s = SHOW_SUSPEND;
    else if (ovc)   s = SHOW_OVC;
    else if (bab)   s = SHOW_BABBLE;
    else if (conn)  s = SHOW_DEVICE;
    else            s = SHOW_EMPTY;
    return s;
  endfunction

  // speed lamp steady, the other lamp blinks while traffic is stretched
  function automatic led_pair_t device_pattern(input logic low_speed,
                                               input logic busy,
                                               input logic phase);
    led_pair_t p;
    if (low_speed) begin
      p.yel = 1'b1;
      p.grn = busy & phase;
    end else begin
      p.grn = 1'b1;
      p.yel = busy & phase;
    end
    return p;
  endfunction

endpackage

// File: rtl/hub_led_timebase.sv
module hub_led_timebase #(
  parameter int HALF_PERIOD = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R10: phase only moves at the end of a half period
  a_r10_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != LAST) |=> $stable(phase));
  a_r10_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> (phase != $past(phase)));

endmodule

// File: rtl/hub_led_stretch.sv
module hub_led_stretch #(
  parameter int HOLD = 24_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic busy
);
  localparam int SW = $clog2(HOLD + 1);

  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (pulse)        left <= SW'(HOLD);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R11: a pulse always opens a window on the next cycle
  a_r11_pulse_opens: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> busy);
  a_r11_window_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !busy) |=> !busy);

endmodule

// File: rtl/hub_led_port.sv
module hub_led_port
  import hub_led_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lamp,
  input  logic bus_reset,
  input  logic bus_suspend,
  input  logic phase,
  input  logic conn,
  input  logic low_speed,
  input  logic pwr,
  input  logic busy,
  input  logic ovc_in,
  input  logic bab_in,
  output logic yel,
  output logic grn
);
  logic      pwr_q;
  logic      ovc_lat;
  logic      bab_lat;
  logic      clr;
  show_e     show;
  led_pair_t dev;
  led_pair_t nxt;

  assign clr = ~conn | (pwr & ~pwr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      ovc_lat <= 1'b0;
      bab_lat <= 1'b0;
    end else begin
      pwr_q   <= pwr;
      ovc_lat <= ovc_in | (ovc_lat & ~clr);
      bab_lat <= bab_in | (bab_lat & ~clr);
    end
  end

  always_comb begin
    show = pick_show(lamp, bus_reset, bus_suspend, ovc_lat, bab_lat, conn);
    dev  = device_pattern(low_speed, busy, phase);
    case (show)
      SHOW_LAMP, SHOW_RESET: nxt = '{yel: 1'b1,   grn: 1'b1};
      SHOW_OVC:              nxt = '{yel: phase,  grn: phase};
      SHOW_BABBLE:           nxt = '{yel: phase,  grn: ~phase};
      SHOW_DEVICE:           nxt = dev;
      default:               nxt = '{yel: 1'b0,   grn: 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yel <= 1'b1;
      grn <= 1'b1;
    end else begin
      yel <= nxt.yel;
      grn <= nxt.grn;
    end
  end

  // R1: lamp test lights both
  a_r1_lamp_on: assert property (@(posedge clk) disable iff (!rst_n)
    lamp |=> (yel && grn));
  // R2: bus reset lights both
  a_r2_reset_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp && bus_reset) |=> (yel && grn));
  // R3: suspend darkens both
  a_r3_suspend_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp && !bus_reset && bus_suspend) |=> (!yel && !grn));
  // R6: overcurrent blinks in phase
  a_r6_ovc_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp && !bus_reset && !bus_suspend && ovc_lat) |=> (yel == grn));
  // R7: babble blinks in anti-phase
  a_r7_babble_anti: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp && !bus_reset && !bus_suspend && !ovc_lat && bab_lat) |=> (yel != grn));
  // R8: a fault event is always latched
  a_r8_ovc_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_in |=> ovc_lat);
  a_r8_bab_latched: assert property (@(posedge clk) disable iff (!rst_n)
    bab_in |=> bab_lat);
  // R9: empty port is dark
  a_r9_empty_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp && !bus_reset && !conn && !ovc_lat && !bab_lat) |=> (!yel && !grn));

endmodule

// File: rtl/hub_port_led.sv
module hub_port_led #(
  parameter int N_PORTS  = 7,
  parameter int CLK_HZ   = 48_000_000,
  parameter int BLINK_HZ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enum_done,
  input  logic               bus_reset,
  input  logic               bus_suspend,
  input  logic [N_PORTS-1:0] port_conn,
  input  logic [N_PORTS-1:0] port_low_speed,
  input  logic [N_PORTS-1:0] port_pwr,
  input  logic [N_PORTS-1:0] port_traffic,
  input  logic [N_PORTS-1:0] port_overcurrent,
  input  logic [N_PORTS-1:0] port_babble,
  output logic [N_PORTS-1:0] led_yel,
  output logic [N_PORTS-1:0] led_grn
);
  localparam int HALF_PERIOD = CLK_HZ / BLINK_HZ;
  localparam int HOLD        = 2 * HALF_PERIOD;

  logic enum_seen;
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enum_seen <= 1'b0;
    else if (enum_done) enum_seen <= 1'b1;
  end

  // R1: once enumerated, the lamp test never returns
  a_r1_enum_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    enum_seen |=> enum_seen);

  hub_led_timebase #(.HALF_PERIOD(HALF_PERIOD)) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic busy;

    hub_led_stretch #(.HOLD(HOLD)) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .pulse (port_traffic[p]),
      .busy  (busy)
    );

    hub_led_port u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .lamp        (~enum_seen),
      .bus_reset   (bus_reset),
      .bus_suspend (bus_suspend),
      .phase       (phase),
      .conn        (port_conn[p]),
      .low_speed   (port_low_speed[p]),
      .pwr         (port_pwr[p]),
      .busy        (busy),
      .ovc_in      (port_overcurrent[p]),
      .bab_in      (port_babble[p]),
      .yel         (led_yel[p]),
      .grn         (led_grn[p])
    );
  end

endmodule

// File: tb/test_hub_port_led.sv
`timescale 1ns/1ps
module test_hub_port_led;
  localparam int N    = 7;
  localparam int CHZ  = 32;
  localparam int BHZ  = 4;
  localparam int HALF = CHZ / BHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enum_done = 1'b0, bus_reset = 1'b0, bus_suspend = 1'b0;
  logic [N-1:0] conn = '0, ls = '0, pwr = '0, traf = '0, ovc = '0, bab = '0;
  logic [N-1:0] led_yel, led_grn;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hub_port_led #(.N_PORTS(N), .CLK_HZ(CHZ), .BLINK_HZ(BHZ)) i_hub_port_led (
    .clk(clk), .rst_n(rst_n), .enum_done(enum_done), .bus_reset(bus_reset),
    .bus_suspend(bus_suspend), .port_conn(conn), .port_low_speed(ls),
    .port_pwr(pwr), .port_traffic(traf), .port_overcurrent(ovc),
    .port_babble(bab), .led_yel(led_yel), .led_grn(led_grn));

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_pair(input int p, input bit ey, input bit eg, input string req);
    check(led_yel[p] == ey && led_grn[p] == eg, req, $sformatf("port %0d yel/grn", p),
          {led_yel[p], led_grn[p]}, {ey, eg});
  endtask

  // mode 0 in phase, 1 anti-phase, 2 yellow steady + green blinks, 3 green steady + yellow blinks
  task automatic watch(input int p, input int mode, input string req);
    bit sy0 = 0, sy1 = 0, sg0 = 0, sg1 = 0;
    int errs = 0;
    bit varied;
    for (int i = 0; i < 2 * HALF; i++) begin
      tick(1);
      if (led_yel[p]) sy1 = 1; else sy0 = 1;
      if (led_grn[p]) sg1 = 1; else sg0 = 1;
      case (mode)
        0: if (led_yel[p] != led_grn[p]) errs++;
        1: if (led_yel[p] == led_grn[p]) errs++;
        2: if (!led_yel[p]) errs++;
        default: if (!led_grn[p]) errs++;
      endcase
    end
    varied = (mode == 2) ? (sg0 && sg1) : (sy0 && sy1);
    check(errs == 0 && varied, req, $sformatf("port %0d blink mode %0d (mismatches,varied)", p, mode),
          errs * 2 + int'(varied), 1);
  endtask

  task automatic all_equal(input bit v, input int cycles, input string req);
    int errs = 0;
    for (int i = 0; i < cycles; i++) begin
      if (led_yel != {N{v}} || led_grn != {N{v}}) errs++;
      tick(1);
    end
    check(errs == 0, req, $sformatf("all lamps %0d over window (mismatches)", v), errs, 0);
  endtask

  task automatic t_reset_state();
    check(led_yel == {N{1'b1}} && led_grn == {N{1'b1}}, "R1", "lamps during reset",
          {led_yel, led_grn}, {2*N{1'b1}});
    rst_n = 1'b1;
    tick(3);
    all_equal(1'b1, 4, "R1");
    enum_done = 1'b1;
    tick(1);
    check(led_yel[0] && led_grn[0], "R1", "still on one edge after enum_done", led_yel[0], 1);
    tick(1);
    check(led_yel == '0 && led_grn == '0, "R9", "empty ports dark after lamp test",
          {led_yel, led_grn}, 0);
    enum_done = 1'b0;
    tick(2);
    check(led_yel == '0 && led_grn == '0, "R1", "lamp test does not return", {led_yel, led_grn}, 0);
  endtask

  task automatic t_low_speed(input int p);
    conn[p] = 1'b1; ls[p] = 1'b1; pwr[p] = 1'b1;
    check_pair(p, 1'b0, 1'b0, "R12");
    tick(1);
    check_pair(p, 1'b1, 1'b0, "R4");
    traf[p] = 1'b1;
    tick(1);
    traf[p] = 1'b0;
    watch(p, 2, "R4");
    tick(1);
    check_pair(p, 1'b1, 1'b0, "R11");
  endtask

  task automatic t_full_speed(input int p);
    conn[p] = 1'b1; ls[p] = 1'b0; pwr[p] = 1'b1;
    tick(1);
    check_pair(p, 1'b0, 1'b1, "R5");
    traf[p] = 1'b1;
    tick(1);
    traf[p] = 1'b0;
    watch(p, 3, "R5");
    tick(1);
    check_pair(p, 1'b0, 1'b1, "R11");
  endtask

  task automatic t_overcurrent(input int p);
    int gap = 0;
    bit prev;
    conn[p] = 1'b1; ls[p] = 1'b0; pwr[p] = 1'b1;
    tick(1);
    ovc[p] = 1'b1;
    tick(1);
    ovc[p] = 1'b0;
    watch(p, 0, "R6");
    watch(p, 0, "R8");
    prev = led_yel[p];
    for (int i = 0; i < 3 * HALF && led_yel[p] == prev; i++) tick(1);
    prev = led_yel[p];
    for (int i = 0; i < 3 * HALF && (gap == 0 || led_yel[p] == prev); i++) begin
      tick(1);
      gap++;
    end
    check(gap == HALF, "R10", "blink half period in cycles", gap, HALF);
    bab[p] = 1'b1;
    tick(1);
    bab[p] = 1'b0;
    watch(p, 0, "R6");
    conn[p] = 1'b0;
    tick(2);
    check_pair(p, 1'b0, 1'b0, "R8");
    conn[p] = 1'b1;
    tick(1);
    check_pair(p, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_babble(input int p);
    conn[p] = 1'b1; ls[p] = 1'b0; pwr[p] = 1'b1;
    tick(1);
    bab[p] = 1'b1;
    tick(1);
    bab[p] = 1'b0;
    watch(p, 1, "R7");
    pwr[p] = 1'b0;
    tick(1);
    pwr[p] = 1'b1;
    tick(1);
    tick(1);
    check_pair(p, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_bus_states(input int p);
    conn[p] = 1'b1; ls[p] = 1'b0; pwr[p] = 1'b1;
    ovc[p] = 1'b1;
    tick(1);
    ovc[p] = 1'b0;
    bus_reset = 1'b1;
    tick(1);
    all_equal(1'b1, 2 * HALF, "R2");
    bus_suspend = 1'b1;
    tick(1);
    all_equal(1'b1, HALF, "R2");
    bus_reset = 1'b0;
    tick(1);
    all_equal(1'b0, 2 * HALF, "R3");
    bus_suspend = 1'b0;
    tick(1);
    check_pair(1, 1'b1, 1'b0, "R12");
    watch(p, 0, "R6");
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_low_speed(1);
    t_full_speed(3);
    t_overcurrent(4);
    t_babble(5);
    t_bus_states(6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule